// File: doc/BRIEF.md
# Serial Configuration and Status Register Bank

This block is a serial slave for a clock-phase controller. An external master using SPI mode 1 sends frames of one command byte, then a data phase. A write frame carries a 16-bit word for one of eight per-channel configuration registers. A read frame returns either a configuration word or a status byte assembled from live per-channel flags. The same command byte can also request a one-cycle clear pulse for the channel charge pumps. One reserved command links the serial input straight to the serial output so the serial chain can be tested.

All serial pins are brought into the system clock domain and processed there, so the serial clock must be several times slower than `clk_i`. Each configuration bit is stored in three flip-flops and read through a 2-of-3 vote, so a single upset flip-flop does not change the word. All eight voted words are brought out on one flat bus.

The serial output is open drain. The block only indicates when to pull the line low, and an external pull-up supplies the high level.

Top module: `cfg_spi_bank`

## Requirements
- R1: After reset, every configuration word is 0x9E00. In that value, bit 15 is the clock-output enable (1), bits 13..9 hold phase A (0x0F), bits 8..4 hold phase B (0) and bits 1..0 hold the drive-strength code (0). Also after reset, `pump_clr_o` is low and the serial output is released.
- R2: The block follows SPI mode 1 with the clock idle low. It samples input bits on the falling serial-clock edge, changes output bits after the rising edge, and shifts both directions MSB first.
- R3: The command byte is the first byte of the frame. Bit 7 selects read (1) or write (0). Bit 6 requests a pump clear. Bit 5 selects status (1) or configuration (0). Bits 4..0 form the select field `sel`.
- R4: Configuration selects 0x00 to 0x03 and 0x10 to 0x13 map to word index {sel[4], sel[1], sel[0]}. That word appears on `cfg_o[16*index +: 16]`. Within each channel, the phase A/B word comes before the sampling-clock word.
- R5: A write takes effect only after 16 data bits have followed the command byte. If the frame ends earlier, no register changes.
- R6: A configuration read returns the stored 16-bit word in the 16 bit slots that follow the command byte.
- R7: Status reads with sel 0x00, 0x01, 0x10 and 0x11 (commands 0xA0, 0xA1, 0xB0, 0xB1) return channel {sel[4], sel[0]}. The byte is {slow_err, locked, near_limit, 5'b0}, taken from `sts_i[3*ch +: 3]` with slow_err as the MSB. The byte is followed by zeros. A read of any other status or configuration select returns all zeros.
- R8: Each command byte with bit 6 set raises `pump_clr_o` for exactly one `clk_i` cycle. Command bytes with bit 6 clear raise no pulse.
- R9: After command 0xFF, the serial output follows the serial input until the frame ends.
- R10: `sdo_low_o` is high only while a 0 is being driven. It is low whenever the enable is high.
- R11: Writes to status selects or to unmapped configuration selects change no register.
- R12: Driving `rst_ni` low presets all configuration words to 0x9E00 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset and preset of the configuration memory |
| sclk_i | input | 1 | Serial clock from the master |
| cs_ni | input | 1 | Frame enable, active low |
| mosi_i | input | 1 | Serial data from the master |
| sdo_low_o | output | 1 | Open-drain control: 1 pulls the serial output low |
| sts_i | input | 12 | Status flags, 3 per channel: {slow_err, locked, near_limit} |
| cfg_o | output | 128 | Eight voted configuration words, word i at bits 16*i +: 16 |
| pump_clr_o | output | 1 | One-cycle charge-pump clear pulse |

## Verification
The hardest case to reach from the ports is a frame that ends between the command byte and the last data bit. The write must then be dropped, even though the command has already been decoded and, when bit 6 is set, has already fired a pump clear. The stimulus reaches this case by raising the enable after 10 bits, and separately after a bare 0x40 byte. It then reads the addressed word back and checks it against its old value and against the pulse count. Bypass is reached by holding the enable low after 0xFF and toggling the input while the output is observed.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
  localparam int          N_CH      = 4;
  localparam int          CFG_W     = 16;
  localparam int          FLAG_W    = 3;
  localparam int          N_REG     = 2 * N_CH;
  localparam logic [15:0] CFG_RST   = 16'h9E00;
  localparam logic [7:0]  CMD_BYPASS = 8'hFF;
  localparam int          CMD_RD    = 7;
  localparam int          CMD_PUMP  = 6;
  localparam int          CMD_STS   = 5;
endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
  parameter int         W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      s2_q <= RST;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cfg_tmr_word.sv
module cfg_tmr_word #(
  parameter int         W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] cp_q [3];

  for (genvar k = 0; k < 3; k++) begin : g_copy
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cp_q[k] <= RST;
      else if (we_i) cp_q[k] <= d_i;
    end
  end

  // 2-of-3 vote per bit
  assign q_o = (cp_q[0] & cp_q[1]) | (cp_q[0] & cp_q[2]) | (cp_q[1] & cp_q[2]);
endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              cs_act_i,
  input  logic              mosi_s_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic [7:0]        cmd_q_o,
  output logic              cmd_stb_o,
  output logic              wr_stb_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              rd_act_o,
  output logic              bypass_o,
  output logic              sdo_bit_o
);
  import cfg_spi_pkg::*;

  localparam int CNT_W    = $clog2(8 + WORD_W) + 1;
  localparam int CMD_END  = 7;
  localparam int DATA_END = 8 + WORD_W - 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              sclk_d;
  logic              rise, fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] rx_q, rx_nxt, tx_q;
  logic              wr_pend;

  assign rise   = sclk_s_i & ~sclk_d;
  assign fall   = ~sclk_s_i & sclk_d;
  assign rx_nxt = {rx_q[WORD_W-2:0], mosi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d <= 1'b0;
    else         sclk_d <= sclk_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt   <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      cmd_q_o   <= '0;
      cmd_stb_o <= 1'b0;
      wr_pend   <= 1'b0;
      rd_act_o  <= 1'b0;
      bypass_o  <= 1'b0;
      sdo_bit_o <= 1'b1;
    end else if (!cs_act_i) begin
      bit_cnt   <= '0;
      cmd_stb_o <= 1'b0;
      wr_pend   <= 1'b0;
      rd_act_o  <= 1'b0;
      bypass_o  <= 1'b0;
      sdo_bit_o <= 1'b1;
    end else begin
      cmd_stb_o <= 1'b0;
      wr_pend   <= 1'b0;
      if (fall) begin
        rx_q <= rx_nxt;
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == CNT_W'(CMD_END)) begin
          cmd_q_o   <= rx_nxt[7:0];
          cmd_stb_o <= 1'b1;
        end
        if (bit_cnt == CNT_W'(DATA_END)) wr_pend <= 1'b1;
      end
      if (cmd_stb_o) begin
        tx_q     <= rd_word_i;
        rd_act_o <= cmd_q_o[CMD_RD] && (cmd_q_o != CMD_BYPASS);
        bypass_o <= (cmd_q_o == CMD_BYPASS);
      end else if (rise && rd_act_o) begin
        sdo_bit_o <= tx_q[WORD_W-1];
        tx_q      <= {tx_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign wr_stb_o  = wr_pend;
  assign wr_data_o = rx_q;
endmodule

// File: rtl/cfg_spi_bank.sv
module cfg_spi_bank
  import cfg_spi_pkg::*;
#(
  parameter int NCH = N_CH
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_i,
  input  logic                  cs_ni,
  input  logic                  mosi_i,
  output logic                  sdo_low_o,
  input  logic [NCH*FLAG_W-1:0] sts_i,
  output logic [2*NCH*CFG_W-1:0] cfg_o,
  output logic                  pump_clr_o
);
  localparam int NREG = 2 * NCH;
  localparam int IDX_W = $clog2(NREG);

  logic              sclk_s, cs_s, mosi_s;
  logic [7:0]        cmd_q;
  logic              cmd_stb, wr_stb, rd_act, bypass, sdo_bit;
  logic [CFG_W-1:0]  wr_data, rd_word;
  logic [CFG_W-1:0]  word [NREG];
  logic [4:0]        sel;
  logic [IDX_W-1:0]  cfg_idx;
  logic [1:0]        sts_ch;
  logic              cfg_ok, sts_ok, wr_ok;

  cfg_spi_sync #(.W(3), .RST(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, mosi_i}),
    .q_o   ({sclk_s, cs_s, mosi_s})
  );

  cfg_spi_frame #(.WORD_W(CFG_W)) u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_s_i (sclk_s),
    .cs_act_i (~cs_s),
    .mosi_s_i (mosi_s),
    .rd_word_i(rd_word),
    .cmd_q_o  (cmd_q),
    .cmd_stb_o(cmd_stb),
    .wr_stb_o (wr_stb),
    .wr_data_o(wr_data),
    .rd_act_o (rd_act),
    .bypass_o (bypass),
    .sdo_bit_o(sdo_bit)
  );

  // select decode: cfg {sel4,sel1,sel0} with sel3..2 clear; status {sel4,sel0} with sel3..1 clear
  assign sel     = cmd_q[4:0];
  assign cfg_ok  = (sel[3:2] == 2'b00);
  assign sts_ok  = (sel[3:1] == 3'b000);
  assign cfg_idx = IDX_W'({sel[4], sel[1], sel[0]});
  assign sts_ch  = {sel[4], sel[0]};
  assign wr_ok   = wr_stb && !cmd_q[CMD_RD] && !cmd_q[CMD_STS] && cfg_ok;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    cfg_tmr_word #(.W(CFG_W), .RST(CFG_RST)) u_word (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (wr_ok && (cfg_idx == IDX_W'(i))),
      .d_i   (wr_data),
      .q_o   (word[i])
    );
    assign cfg_o[i*CFG_W +: CFG_W] = word[i];
  end

  always_comb begin
    rd_word = '0;
    if (cmd_q[CMD_STS]) begin
      if (sts_ok) rd_word = {sts_i[sts_ch*FLAG_W +: FLAG_W], {(CFG_W-FLAG_W){1'b0}}};
    end else if (cfg_ok) begin
      rd_word = word[cfg_idx];
    end
  end

  assign pump_clr_o = cmd_stb && cmd_q[CMD_PUMP];
  assign sdo_low_o  = bypass ? ~mosi_i : (rd_act && !sdo_bit);
endmodule

// File: rtl/cfg_spi_bank_chk.sv
module cfg_spi_bank_chk
  import cfg_spi_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   cs_ni,
  input logic                   sdo_low_o,
  input logic                   pump_clr_o,
  input logic [N_REG*CFG_W-1:0] cfg_o,
  input logic                   wr_stb,
  input logic [7:0]             cmd_q,
  input logic                   rd_act,
  input logic                   bypass
);
  p_pump_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pump_clr_o |=> !pump_clr_o);

  p_pump_in_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pump_clr_o |-> !$past(cs_ni, 2));

  p_cfg_write_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> ($past(wr_stb) && !$past(cmd_q[CMD_RD]) && !$past(cmd_q[CMD_STS])));

  p_modes_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_act, bypass}));

  p_idle_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !sdo_low_o);
endmodule

bind cfg_spi_bank cfg_spi_bank_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .sdo_low_o (sdo_low_o),
  .pump_clr_o(pump_clr_o),
  .cfg_o     (cfg_o),
  .wr_stb    (wr_stb),
  .cmd_q     (cmd_q),
  .rd_act    (rd_act),
  .bypass    (bypass)
);

// File: tb/cfg_spi_bank_test.sv
module cfg_spi_bank_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sclk = 1'b0;
  logic         cs_n = 1'b1;
  logic         mosi = 1'b0;
  logic         sdo_low;
  logic [11:0]  sts = '0;
  logic [127:0] cfg;
  logic         pump;

  int n_chk = 0, n_err = 0, pump_cnt = 0;
  bit done = 0;

  typedef struct { string req; logic [15:0] val; } item_t;
  item_t       exp_q[$];
  logic [15:0] act_q[$];

  always #4 clk = ~clk;

  cfg_spi_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .sdo_low_o(sdo_low), .sts_i(sts), .cfg_o(cfg), .pump_clr_o(pump)
  );

  always @(posedge clk) if (pump) pump_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0; wclk(8);
  endtask

  task automatic cs_hi();
    wclk(8); cs_n = 1'b1; wclk(12);
  endtask

  // R2: launch on rising edge, sample line just before falling edge
  task automatic shift(input int nbits, input logic [31:0] tx, output logic [31:0] rx);
    rx = '0;
    for (int i = nbits - 1; i >= 0; i--) begin
      sclk = 1'b1; mosi = tx[i];
      wclk(8);
      rx[i] = ~sdo_low;
      sclk = 1'b0;
      wclk(8);
    end
  endtask

  task automatic xfer(input int nbits, input logic [31:0] tx, output logic [31:0] rx);
    cs_lo(); shift(nbits, tx, rx); cs_hi();
  endtask

  task automatic wr(input logic [7:0] cmd, input logic [15:0] d);
    logic [31:0] rx;
    xfer(24, {8'h0, cmd, d}, rx);
  endtask

  // scoreboard driver: push expected, run frame, hand captured word to monitor
  task automatic rd(input logic [7:0] cmd, input logic [15:0] exp, input string req);
    logic [31:0] rx;
    item_t it;
    it.req = req; it.val = exp;
    exp_q.push_back(it);
    xfer(24, {8'h0, cmd, 16'hFFFF}, rx);
    act_q.push_back(rx[15:0]);
  endtask

  initial begin : monitor
    forever begin
      item_t it;
      logic [15:0] a;
      wait (act_q.size() > 0);
      a  = act_q.pop_front();
      it = exp_q.pop_front();
      chk(it.req, {16'h0, a}, {16'h0, it.val});
    end
  end

  function automatic logic [15:0] slot(input int i);
    return cfg[i*16 +: 16];
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rx;
    int p0;
    // ch0=101 ch1=010 ch2=111 ch3=001
    sts = {3'b001, 3'b111, 3'b010, 3'b101};
    wclk(5);
    // R1 reset state
    for (int i = 0; i < 8; i++) chk("R1 reset word", {16'h0, slot(i)}, 32'h9E00);
    chk("R1 pump idle", {31'h0, pump}, 0);
    chk("R1 line released", {31'h0, sdo_low}, 0);
    rst_n = 1'b1;
    wclk(5);

    // R6/R2 read default
    rd(8'h80, 16'h9E00, "R6 read default");
    // R4/R5 write and read back
    wr(8'h01, 16'h1234);
    chk("R4 R5 slot1", {16'h0, slot(1)}, 32'h1234);
    rd(8'h81, 16'h1234, "R6 read slot1");
    wr(8'h13, 16'hA5C3);
    chk("R4 slot7", {16'h0, slot(7)}, 32'hA5C3);
    rd(8'h93, 16'hA5C3, "R6 read slot7");
    wr(8'h12, 16'h0F0F);
    chk("R4 slot6", {16'h0, slot(6)}, 32'h0F0F);
    chk("R4 slot5 untouched", {16'h0, slot(5)}, 32'h9E00);
    // R10: open-drain read of mixed bits
    rd(8'h92, 16'h0F0F, "R10 open drain data");

    // R5 partial frame discarded
    xfer(18, {14'h0, 8'h00, 10'h3FF}, rx);
    chk("R5 partial discarded", {16'h0, slot(0)}, 32'h9E00);

    // R11 unmapped and status writes ignored
    wr(8'h04, 16'hFFFF);
    wr(8'h20, 16'h0000);
    wr(8'h0C, 16'h0000);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] e;
      e = (i == 1) ? 16'h1234 : (i == 7) ? 16'hA5C3 : (i == 6) ? 16'h0F0F : 16'h9E00;
      chk("R11 no change", {16'h0, slot(i)}, {16'h0, e});
    end

    // R7 status reads
    rd(8'hA0, 16'hA000, "R7 status ch0");
    rd(8'hA1, 16'h4000, "R7 status ch1");
    rd(8'hB0, 16'hE000, "R7 status ch2");
    rd(8'hB1, 16'h2000, "R7 status ch3");
    rd(8'hA2, 16'h0000, "R7 unmapped status");
    rd(8'h84, 16'h0000, "R7 unmapped cfg");
    sts = 12'h000;
    rd(8'hB0, 16'h0000, "R7 live flags");

    // R8 pump pulses
    p0 = pump_cnt;
    xfer(8, 32'h40, rx);
    chk("R8 pump 0x40", pump_cnt - p0, 1);
    chk("R3 R5 0x40 no write", {16'h0, slot(0)}, 32'h9E00);
    rd(8'hC1, 16'h1234, "R3 read with pump");
    chk("R8 pump on read", pump_cnt - p0, 2);
    rd(8'h80, 16'h9E00, "R8 no pump read");
    chk("R8 no pulse without bit6", pump_cnt - p0, 2);

    // R9 bypass
    cs_lo();
    shift(8, 32'hFF, rx);
    wclk(8);
    mosi = 1'b0; wclk(2);
    chk("R9 bypass low", {31'h0, ~sdo_low}, 0);
    mosi = 1'b1; wclk(2);
    chk("R9 bypass high", {31'h0, ~sdo_low}, 1);
    mosi = 1'b0; wclk(2);
    chk("R9 bypass low again", {31'h0, ~sdo_low}, 0);
    cs_hi();
    chk("R10 released after frame", {31'h0, sdo_low}, 0);

    // R12 asynchronous preset
    @(posedge clk); #1;
    rst_n = 1'b0; #1;
    chk("R12 async slot1", {16'h0, slot(1)}, 32'h9E00);
    chk("R12 async slot7", {16'h0, slot(7)}, 32'h9E00);
    wclk(3);
    rst_n = 1'b1;
    wclk(4);
    rd(8'h93, 16'h9E00, "R12 read after preset");

    wait (act_q.size() == 0);
    wclk(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule